// File: doc/BRIEF.md
# Prescaled Timer with Match and Capture Channels

A counter block that advances either on every cycle of its own clock or on chosen edges of one external event line. The count is fed through a programmable prescaler: the counter moves up by one each time the prescaler has seen its limit value plus one qualifying ticks. Four match channels compare their stored value with the counter. When a match occurs, a channel can raise a flag, send the counter back to zero or halt counting. Four capture channels watch external lines and copy the counter into a holding register on a rising edge, a falling edge or both.

Every external line goes through a two-stage synchronizer. Edges are found by comparing two successive synchronized samples, so an external event source is counted reliably only up to half the clock rate. Any one capture line can be picked as the count source. All capture channels, that line included, go on capturing as normal. Software reaches the block through a simple word-wide register port with a combinational read. Interrupt flags are sticky and are cleared by writing ones. A single interrupt line reports any flag whose enable is set.

Top module: `tm_timer`

## Requirements
- R1: After reset, every readable register reads zero, `irq_o` is low and `match_o` is zero.
- R2: With the clock as count source (control bit 2 clear) and the enable (control bit 0) set, the counter (address 2) advances by one every PRESCALE+1 cycles, where PRESCALE is held at address 1. While the enable is clear the counter holds.
- R3: A write to address 2 loads the counter and restarts the prescaler from zero.
- R4: With control bit 2 set, the prescaler is ticked by edges of the capture line selected by control bits 6:5: rising edges when control bit 3 is set, falling edges when control bit 4 is set. Event edges one clock cycle apart cannot both be detected.
- R5: Match channel i (value at address 8+i) sets flag bit i when the counter advances while equal to its value. It pulses `match_o[i]` in the same cycle, and counting continues.
- R6: If bit 3i+1 of the match control register (address 4) is set, a match on channel i returns the counter to zero in place of incrementing it.
- R7: If bit 3i+2 of address 4 is set, a match on channel i clears the enable bit and leaves the counter at the matched value.
- R8: Capture channel i (address 16+i) stores the counter value on a rising edge if bit 3i of the capture control register (address 5) is set, or on a falling edge if bit 3i+1 is set. The value stored is the one the counter holds two cycles after the line changes. An edge that is not selected leaves the register unchanged.
- R9: While capture line s is the count source, every other capture channel keeps capturing as normal.
- R10: Flag register (address 3): bits 3:0 are the match flags and bits 7:4 the capture flags. Writing a one clears a bit. A set event in the same cycle as the clear keeps the bit set.
- R11: `irq_o` is high exactly when some flag is set whose enable is set. Enables are bit 3i of address 4 for match channel i and bit 3i+2 of address 5 for capture channel i.
- R12: While control bit 1 is set, the counter and the prescaler are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational on address |
| cap_i | input | 4 | Asynchronous capture / event lines |
| match_o | output | 4 | One-cycle pulse per match channel on a match |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle. The first is a match setting its flag while software writes a one to clear that flag. The bench enables counting with a known match value and times the write-one-to-clear so that it lands on the exact edge where the match fires. It expects the flag to read back as set. A clear issued one cycle later must then empty the flag. The second is a capture edge arriving on a cycle where the counter increments. The bench places capture edges at chosen cycle offsets after enabling and computes the stored value from the two-cycle synchronizer delay. This shows that the pre-increment count is the one held.

// File: rtl/tm_pkg.sv
package tm_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_PRESC = 5'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 5'd2;
  localparam logic [ADDR_W-1:0] A_FLAGS = 5'd3;
  localparam logic [ADDR_W-1:0] A_MCTL  = 5'd4;
  localparam logic [ADDR_W-1:0] A_CCTL  = 5'd5;
  localparam int unsigned A_MATCH_BASE = 8;
  localparam int unsigned A_CAP_BASE   = 16;

  // control register bit positions
  localparam int unsigned C_EN   = 0;
  localparam int unsigned C_CLR  = 1;
  localparam int unsigned C_EXT  = 2;
  localparam int unsigned C_RISE = 3;
  localparam int unsigned C_FALL = 4;
  localparam int unsigned C_SEL  = 5;

  typedef struct packed {
    logic stop;
    logic zero;
    logic irq_en;
  } mctl_t;

  typedef struct packed {
    logic irq_en;
    logic on_fall;
    logic on_rise;
  } cctl_t;
endpackage

// File: rtl/tm_edge_det.sv
module tm_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;

  // two sampled edges can never be adjacent: source rate limit
  assert_edge_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  assert_fall_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tm_prescale.sv
module tm_prescale #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          adv_o
);
  logic [CW-1:0] pc_q;

  assign adv_o = tick_i && (pc_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (clr_i)   pc_q <= '0;
    else if (tick_i)  pc_q <= adv_o ? '0 : pc_q + 1'b1;
  end

  assert_pc_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pc_q == '0));
endmodule

// File: rtl/tm_capture.sv
module tm_capture #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          on_rise_i,
  input  logic          on_fall_i,
  input  logic [CW-1:0] count_i,
  output logic          hit_o,
  output logic [CW-1:0] value_o
);
  assign hit_o = (rise_i & on_rise_i) | (fall_i & on_fall_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    value_o <= '0;
    else if (hit_o) value_o <= count_i;
  end

  assert_cap_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |=> $stable(value_o));
endmodule

// File: rtl/tm_timer.sv
module tm_timer
  import tm_pkg::*;
#(
  parameter int unsigned CW      = 32,
  parameter int unsigned N_MATCH = 4,
  parameter int unsigned N_CAP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CW-1:0]     reg_wdata_i,
  output logic [CW-1:0]     reg_rdata_o,
  input  logic [N_CAP-1:0]  cap_i,
  output logic [N_MATCH-1:0] match_o,
  output logic              irq_o
);
  localparam int unsigned SEL_W = (N_CAP > 1) ? $clog2(N_CAP) : 1;
  localparam int unsigned NF    = N_MATCH + N_CAP;
  localparam int unsigned MC_W  = 3 * N_MATCH;
  localparam int unsigned CC_W  = 3 * N_CAP;

  // control
  logic             en_q, clr_q, ext_q, erise_q, efall_q;
  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    presc_q, tc_q;
  logic [NF-1:0]    flags_q;
  mctl_t [N_MATCH-1:0] mctl_q;
  cctl_t [N_CAP-1:0]   cctl_q;
  logic [CW-1:0]    mval_q [N_MATCH];
  logic [CW-1:0]    cval   [N_CAP];

  logic wr_ctrl, wr_count, wr_flags;
  assign wr_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_count = reg_we_i && (reg_addr_i == A_COUNT);
  assign wr_flags = reg_we_i && (reg_addr_i == A_FLAGS);

  // edge detection on every external line
  logic [N_CAP-1:0] rise_v, fall_v, cap_hit;
  for (genvar c = 0; c < N_CAP; c++) begin : g_line
    tm_edge_det u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (cap_i[c]),
      .rise_o (rise_v[c]),
      .fall_o (fall_v[c])
    );
    tm_capture #(.CW(CW)) u_cap (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rise_i    (rise_v[c]),
      .fall_i    (fall_v[c]),
      .on_rise_i (cctl_q[c].on_rise),
      .on_fall_i (cctl_q[c].on_fall),
      .count_i   (tc_q),
      .hit_o     (cap_hit[c]),
      .value_o   (cval[c])
    );
  end

  // count source
  logic ext_ev, tick, adv;
  assign ext_ev = (erise_q & rise_v[sel_q]) | (efall_q & fall_v[sel_q]);
  assign tick   = en_q && (ext_q ? ext_ev : 1'b1);

  tm_prescale #(.CW(CW)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_q | wr_count),
    .tick_i  (tick),
    .limit_i (presc_q),
    .adv_o   (adv)
  );

  // match compare
  logic [N_MATCH-1:0] hit, zero_en, stop_en;
  for (genvar m = 0; m < N_MATCH; m++) begin : g_match
    assign hit[m]     = adv && (tc_q == mval_q[m]);
    assign zero_en[m] = mctl_q[m].zero;
    assign stop_en[m] = mctl_q[m].stop;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mval_q[m] <= '0;
      else if (reg_we_i && (reg_addr_i == ADDR_W'(A_MATCH_BASE + m)))
        mval_q[m] <= reg_wdata_i;
    end
  end
  assign match_o = hit;

  logic zero_any, stop_any;
  assign zero_any = |(hit & zero_en);
  assign stop_any = |(hit & stop_en);

  // counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tc_q <= '0;
    else if (clr_q)    tc_q <= '0;
    else if (wr_count) tc_q <= reg_wdata_i;
    else if (adv) begin
      if (zero_any)      tc_q <= '0;
      else if (!stop_any) tc_q <= tc_q + 1'b1;
    end
  end

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      clr_q   <= 1'b0;
      ext_q   <= 1'b0;
      erise_q <= 1'b0;
      efall_q <= 1'b0;
      sel_q   <= '0;
      presc_q <= '0;
      mctl_q  <= '0;
      cctl_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= reg_wdata_i[C_EN];
        clr_q   <= reg_wdata_i[C_CLR];
        ext_q   <= reg_wdata_i[C_EXT];
        erise_q <= reg_wdata_i[C_RISE];
        efall_q <= reg_wdata_i[C_FALL];
        sel_q   <= reg_wdata_i[C_SEL +: SEL_W];
      end else if (stop_any) begin
        en_q <= 1'b0;
      end
      if (reg_we_i && reg_addr_i == A_PRESC) presc_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == A_MCTL)  mctl_q  <= reg_wdata_i[MC_W-1:0];
      if (reg_we_i && reg_addr_i == A_CCTL)  cctl_q  <= reg_wdata_i[CC_W-1:0];
    end
  end

  // sticky flags, set beats clear
  logic [NF-1:0] set_v, clr_v, ien_v;
  assign set_v = {cap_hit, hit};
  assign clr_v = wr_flags ? reg_wdata_i[NF-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_v) | set_v;
  end

  for (genvar m = 0; m < N_MATCH; m++) begin : g_mien
    assign ien_v[m] = mctl_q[m].irq_en;
  end
  for (genvar c = 0; c < N_CAP; c++) begin : g_cien
    assign ien_v[N_MATCH + c] = cctl_q[c].irq_en;
  end
  assign irq_o = |(flags_q & ien_v);

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:  begin
        reg_rdata_o[C_EN]          = en_q;
        reg_rdata_o[C_CLR]         = clr_q;
        reg_rdata_o[C_EXT]         = ext_q;
        reg_rdata_o[C_RISE]        = erise_q;
        reg_rdata_o[C_FALL]        = efall_q;
        reg_rdata_o[C_SEL +: SEL_W] = sel_q;
      end
      A_PRESC: reg_rdata_o = presc_q;
      A_COUNT: reg_rdata_o = tc_q;
      A_FLAGS: reg_rdata_o[NF-1:0] = flags_q;
      A_MCTL:  reg_rdata_o[MC_W-1:0] = mctl_q;
      A_CCTL:  reg_rdata_o[CC_W-1:0] = cctl_q;
      default: begin
        for (int m = 0; m < N_MATCH; m++)
          if (reg_addr_i == ADDR_W'(A_MATCH_BASE + m)) reg_rdata_o = mval_q[m];
        for (int c = 0; c < N_CAP; c++)
          if (reg_addr_i == ADDR_W'(A_CAP_BASE + c)) reg_rdata_o = cval[c];
      end
    endcase
  end

  assert_tc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv && !wr_count && !clr_q) |=> $stable(tc_q));
  assert_zero_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_any && !wr_count && !clr_q) |=> (tc_q == '0));
  assert_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_any && !wr_ctrl) |=> !en_q);
  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_v) |=> ((flags_q & $past(set_v)) == $past(set_v)));
  assert_irq_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q == '0) |-> !irq_o);
endmodule

// File: tb/tm_timer_tb.sv
module tm_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cap = '0;
  logic [3:0]  match;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tm_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cap_i(cap),
    .match_o(match), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called just after a negedge; write lands on the next posedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int idx);
    cap[idx] = 1'b1; @(negedge clk);
    cap[idx] = 1'b0; @(negedge clk);
  endtask

  task automatic fresh(input logic [31:0] presc);
    wr(5'd0, 32'd0);
    wr(5'd2, 32'd0);
    wr(5'd1, presc);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 32; a++) begin
      rd(a[4:0], v); chk("R1", v, 0);
    end
    chk("R1", {31'd0, irq}, 0);
    chk("R1", {28'd0, match}, 0);

    // R2 prescale sweep
    for (int p = 0; p < 4; p++) begin
      for (int n = 5; n <= 11; n += 6) begin
        fresh(p);
        wr(5'd0, 32'd1);
        repeat (n) @(negedge clk);
        rd(5'd2, v); chk("R2", v, n / (p + 1));
      end
    end
    wr(5'd0, 32'd0);
    rd(5'd2, v);
    repeat (5) @(negedge clk);
    begin logic [31:0] w; rd(5'd2, w); chk("R2", w, v); end

    // R3 load then count
    fresh(2);
    wr(5'd2, 32'd100);
    wr(5'd0, 32'd1);
    repeat (7) @(negedge clk);
    rd(5'd2, v); chk("R3", v, 102);

    // R12 clear bit holds count at zero
    wr(5'd0, 32'd3);
    repeat (6) @(negedge clk);
    rd(5'd2, v); chk("R12", v, 0);
    wr(5'd0, 32'd1);
    repeat (8) @(negedge clk);
    rd(5'd2, v); chk("R12", v, 2);

    // R5 match flags while counting continues, R11 gating
    fresh(0);
    wr(5'd4, 32'd0);
    wr(5'd10, 32'd3);
    wr(5'd3, 32'hFF);
    wr(5'd0, 32'd1);
    repeat (10) @(negedge clk);
    rd(5'd2, v); chk("R5", v, 10);
    rd(5'd3, v); chk("R5", (v >> 2) & 1, 1);
    chk("R11", {31'd0, irq}, 0);
    wr(5'd4, 32'd1 << 6);
    chk("R11", {31'd0, irq}, 1);
    wr(5'd3, 32'h04);
    chk("R11", {31'd0, irq}, 0);

    // R6 match resets counter: count = n mod (M+1)
    for (int m = 2; m <= 4; m++) begin
      fresh(0);
      wr(5'd4, 32'd2);
      wr(5'd8, m);
      wr(5'd0, 32'd1);
      repeat (13) @(negedge clk);
      rd(5'd2, v); chk("R6", v, 13 % (m + 1));
    end

    // R7 stop on match
    fresh(0);
    wr(5'd4, 32'd1 << 5);
    wr(5'd9, 32'd5);
    wr(5'd3, 32'hFF);
    wr(5'd0, 32'd1);
    repeat (10) @(negedge clk);
    rd(5'd2, v); chk("R7", v, 5);
    rd(5'd0, v); chk("R7", v & 1, 0);
    rd(5'd3, v); chk("R7", (v >> 1) & 1, 1);

    // R10 set and clear in the same cycle
    fresh(0);
    wr(5'd4, 32'd2);
    wr(5'd8, 32'd3);
    wr(5'd3, 32'hFF);
    wr(5'd0, 32'd1);
    repeat (3) @(negedge clk);
    wr(5'd3, 32'h01);
    rd(5'd3, v); chk("R10", v & 1, 1);
    wr(5'd3, 32'h01);
    rd(5'd3, v); chk("R10", v & 1, 0);

    // R8 capture rising edge, value = d + 2
    wr(5'd4, 32'd0);
    for (int d = 0; d < 4; d++) begin
      fresh(0);
      wr(5'd5, 32'd1 << 6);
      wr(5'd0, 32'd1);
      repeat (d) @(negedge clk);
      cap[2] = 1'b1;
      repeat (4) @(negedge clk);
      rd(5'd18, v); chk("R8", v, d + 2);
      cap[2] = 1'b0;
      repeat (4) @(negedge clk);
      rd(5'd18, v); chk("R8", v, d + 2);
    end

    // R8 both edges, R11 capture interrupt
    fresh(0);
    wr(5'd5, (32'd3 << 6) | (32'd1 << 8));
    wr(5'd3, 32'hFF);
    chk("R11", {31'd0, irq}, 0);
    wr(5'd0, 32'd1);
    repeat (2) @(negedge clk);
    cap[2] = 1'b1;
    repeat (3) @(negedge clk);
    rd(5'd18, v); chk("R8", v, 4);
    cap[2] = 1'b0;
    repeat (4) @(negedge clk);
    rd(5'd18, v); chk("R8", v, 7);
    rd(5'd3, v); chk("R10", (v >> 6) & 1, 1);
    chk("R11", {31'd0, irq}, 1);

    // R4 external source on line 1
    wr(5'd5, 32'd0);
    fresh(0);
    wr(5'd0, 32'd45);
    for (int k = 0; k < 7; k++) pulse(1);
    repeat (4) @(negedge clk);
    rd(5'd2, v); chk("R4", v, 7);

    fresh(1);
    wr(5'd0, 32'd45);
    for (int k = 0; k < 7; k++) pulse(1);
    repeat (4) @(negedge clk);
    rd(5'd2, v); chk("R4", v, 3);

    fresh(0);
    wr(5'd0, 32'd61);
    for (int k = 0; k < 5; k++) pulse(1);
    repeat (4) @(negedge clk);
    rd(5'd2, v); chk("R4", v, 10);

    // R9 other line still captures while line 1 is the source
    wr(5'd5, 32'd1 << 9);
    pulse(3);
    repeat (4) @(negedge clk);
    rd(5'd19, v); chk("R9", v, 10);
    rd(5'd2, v); chk("R9", v, 10);
    rd(5'd3, v); chk("R9", (v >> 7) & 1, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule